// File: doc/BRIEF.md
# Meter Frame BCD Decoder

This block sits behind a byte-wide serial receiver and turns fixed-length measurement frames into four display digit codes and a set of status indications. It hunts the incoming byte stream for a two-byte header, then counts the rest of the frame. From a window of five body bytes it builds four raw digits. Each raw digit joins the upper nibble of one byte to the lower nibble of the byte after it. A lookup step maps each raw digit to a decimal value or a special code.

The four codes are matched against fixed patterns. These patterns flag an overload reading, a blank or partly blank display, a continuity beep, a mode change and an unrecognised frame. Two bits of a status byte give a 2-bit overload level. All results are registered together at the end of a frame, a one-cycle done strobe marks them, and they hold until the next frame completes.

Top module: `meter_frame_decoder`

## Requirements
- R1: A frame starts only after the byte 0x5A is followed, on the next accepted byte, by 0xA5. Accepted bytes outside a frame have no effect on any output.
- R2: If 0x5A is followed by a byte other than 0xA5, the header search restarts. If that byte is 0x5A again, it counts as a new first header byte, so 0x5A 0x5A 0xA5 opens a frame.
- R3: Frame bytes are numbered from 0, where byte 0 is the first header byte. Raw digit k, for k = 0 to 3, is the upper nibble of frame byte 2+k joined with the lower nibble of frame byte 3+k. Digit code k appears on digit_codes bits [8k+7:8k].
- R4: The lookup returns the raw value unchanged for 0x00–0x09 and for the special codes 0x0A, 0x0B, 0x10, 0x11, 0x12, 0x13 and 0x14. Every other raw value gives 0xFF. frame_invalid is 1 when any of the four codes is 0xFF.
- R5: ovl_pattern is 1 exactly when code 0 is 0x0A and code 1 is 0x0B.
- R6: blank is 1 when codes 0 and 1 are both 0x10. partial_blank is 1 when code 0 is 0x10 and code 1 is 0x11.
- R7: continuity is 1 when code 1 is 0x12, code 2 is 0x0A and code 3 is 0x05.
- R8: mode_change is 1 when code 1 is 0x13 and code 2 is 0x14.
- R9: ovl_flag is 1 when bit 1 of frame byte 7 is set. Otherwise it is 2 when bit 0 is set, and 0 when neither bit is set.
- R10: After reset all outputs are 0. Every output updates on the clock edge that accepts the twelfth frame byte. frame_done is high for exactly the following cycle. Outputs hold between frames.
- R11: Cycles with rx_valid low are ignored, so idle gaps inside a frame do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte strobe from the receiver |
| rx_byte | input | 8 | Received byte, sampled when rx_valid is high |
| digit_codes | output | 32 | Four looked-up digit codes, code k at bits [8k+7:8k] |
| ovl_pattern | output | 1 | Overload digit pattern seen |
| blank | output | 1 | Blank display pattern seen |
| partial_blank | output | 1 | Partly blank pattern seen |
| continuity | output | 1 | Continuity pattern seen |
| mode_change | output | 1 | Mode change pattern seen |
| frame_invalid | output | 1 | At least one code is 0xFF |
| ovl_flag | output | 2 | Overload level from status byte bits 1 and 0 |
| frame_done | output | 1 | One-cycle strobe when outputs have been updated |

## Verification
The case that is hardest to reach from the ports is header recovery: a stray 0x5A, then a non-header byte, then a repeated 0x5A before the real 0xA5. Any slip in the hunt state either opens a frame too early or misses the real one. The stimulus sends such prefixes before a known frame. It then checks that no done strobe appears for the stray bytes, that the held outputs do not change, and that the real frame decodes at the expected offset. Frame bodies also carry 0x5A and 0xA5 as data, so a header detector that wrongly stays armed during a frame is exposed.

// File: rtl/mfd_pkg.sv
package mfd_pkg;

   localparam int DIGITS = 4;

   localparam logic [7:0] CODE_O     = 8'h0A;
   localparam logic [7:0] CODE_L     = 8'h0B;
   localparam logic [7:0] CODE_BLANK = 8'h10;
   localparam logic [7:0] CODE_PART  = 8'h11;
   localparam logic [7:0] CODE_BEEP  = 8'h12;
   localparam logic [7:0] CODE_MODEA = 8'h13;
   localparam logic [7:0] CODE_MODEB = 8'h14;
   localparam logic [7:0] CODE_BAD   = 8'hFF;

   typedef struct packed {
      logic ovl_pat;
      logic blank;
      logic part_blank;
      logic cont;
      logic mode_chg;
      logic invalid;
   } mfd_class_t;

   // map a raw cross-nibble digit to its display code
   function automatic logic [7:0] digit_lookup(input logic [7:0] raw);
      logic [7:0] code;
      if (raw <= 8'h09) begin
         code = raw;
      end else begin
         case (raw)
            CODE_O, CODE_L, CODE_BLANK, CODE_PART,
            CODE_BEEP, CODE_MODEA, CODE_MODEB: code = raw;
            default:                           code = CODE_BAD;
         endcase
      end
      return code;
   endfunction

endpackage

// File: rtl/mfd_hdr_sync.sv
module mfd_hdr_sync #(
   parameter int         FRAME_LEN = 12,
   parameter logic [7:0] HDR0      = 8'h5A,
   parameter logic [7:0] HDR1      = 8'hA5,
   localparam int        CNT_W     = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic [7:0]       rx_byte,
   output logic             body_we,
   output logic [CNT_W-1:0] body_idx,
   output logic             last_byte
);

   typedef enum logic [1:0] {S_HUNT, S_GOT0, S_BODY} hunt_st_t;

   hunt_st_t         st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             in_body;

   assign in_body   = (st_q == S_BODY);
   assign body_we   = rx_valid && in_body;
   assign body_idx  = cnt_q;
   assign last_byte = body_we && (cnt_q == CNT_W'(FRAME_LEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= S_HUNT;
         cnt_q <= '0;
      end else if (rx_valid) begin
         unique case (st_q)
            S_HUNT: begin
               if (rx_byte == HDR0) st_q <= S_GOT0;
            end
            S_GOT0: begin
               if (rx_byte == HDR1) begin
                  st_q  <= S_BODY;
                  cnt_q <= CNT_W'(2);
               end else if (rx_byte != HDR0) begin
                  st_q <= S_HUNT;
               end
            end
            S_BODY: begin
               if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
                  st_q  <= S_HUNT;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: st_q <= S_HUNT;
         endcase
      end
   end

   AST_HDR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_body) |-> ($past(rx_valid) && $past(rx_byte) == HDR1)); // R1

   AST_HDR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_GOT0 && rx_valid && rx_byte == HDR0) |=> (st_q == S_GOT0)); // R2

endmodule

// File: rtl/mfd_capture.sv
module mfd_capture #(
   parameter int  FRAME_LEN = 12,
   parameter int  DIG_BASE  = 2,
   parameter int  STAT_IDX  = 7,
   localparam int CNT_W     = $clog2(FRAME_LEN),
   localparam int NDIG      = mfd_pkg::DIGITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              body_we,
   input  logic [CNT_W-1:0]  body_idx,
   input  logic [7:0]        rx_byte,
   output logic [NDIG*8-1:0] raw_digits,
   output logic [1:0]        stat_bits
);

   // cross-nibble assembly happens at capture time
   for (genvar k = 0; k < NDIG; k++) begin : g_dig
      logic [3:0] hi_q, lo_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
         end else if (body_we) begin
            if (body_idx == CNT_W'(DIG_BASE + k))     hi_q <= rx_byte[7:4];
            if (body_idx == CNT_W'(DIG_BASE + k + 1)) lo_q <= rx_byte[3:0];
         end
      end
      assign raw_digits[8*k +: 8] = {hi_q, lo_q};
   end

   logic [1:0] stat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     stat_q <= '0;
      else if (body_we && body_idx == CNT_W'(STAT_IDX)) stat_q <= rx_byte[1:0];
   end
   assign stat_bits = stat_q;

endmodule

// File: rtl/mfd_digit_lut.sv
module mfd_digit_lut #(
   localparam int NDIG = mfd_pkg::DIGITS
) (
   input  logic [NDIG*8-1:0] raw_digits,
   output logic [NDIG*8-1:0] codes
);

   for (genvar k = 0; k < NDIG; k++) begin : g_lut
      assign codes[8*k +: 8] = mfd_pkg::digit_lookup(raw_digits[8*k +: 8]);
   end

endmodule

// File: rtl/mfd_classify.sv
module mfd_classify
   import mfd_pkg::*;
#(
   localparam int NDIG = mfd_pkg::DIGITS
) (
   input  logic [NDIG*8-1:0] codes,
   input  logic [1:0]        stat_bits,
   output mfd_class_t        cls,
   output logic [1:0]        ovl_level
);

   logic [7:0] c [NDIG];
   logic [NDIG-1:0] bad;

   for (genvar k = 0; k < NDIG; k++) begin : g_split
      assign c[k]   = codes[8*k +: 8];
      assign bad[k] = (codes[8*k +: 8] == CODE_BAD);
   end

   always_comb begin
      cls.ovl_pat    = (c[0] == CODE_O) && (c[1] == CODE_L);
      cls.blank      = (c[0] == CODE_BLANK) && (c[1] == CODE_BLANK);
      cls.part_blank = (c[0] == CODE_BLANK) && (c[1] == CODE_PART);
      cls.cont       = (c[1] == CODE_BEEP) && (c[2] == CODE_O) && (c[3] == 8'h05);
      cls.mode_chg   = (c[1] == CODE_MODEA) && (c[2] == CODE_MODEB);
      cls.invalid    = |bad;
   end

   // bit 1 outranks bit 0
   always_comb begin
      if (stat_bits[1])      ovl_level = 2'd1;
      else if (stat_bits[0]) ovl_level = 2'd2;
      else                   ovl_level = 2'd0;
   end

endmodule

// File: rtl/meter_frame_decoder.sv
module meter_frame_decoder
   import mfd_pkg::*;
#(
   parameter int         FRAME_LEN = 12,
   parameter logic [7:0] HDR0      = 8'h5A,
   parameter logic [7:0] HDR1      = 8'hA5,
   parameter int         DIG_BASE  = 2,
   parameter int         STAT_IDX  = 7,
   localparam int        CNT_W     = $clog2(FRAME_LEN),
   localparam int        NDIG      = mfd_pkg::DIGITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic [NDIG*8-1:0] digit_codes,
   output logic              ovl_pattern,
   output logic              blank,
   output logic              partial_blank,
   output logic              continuity,
   output logic              mode_change,
   output logic              frame_invalid,
   output logic [1:0]        ovl_flag,
   output logic              frame_done
);

   initial begin
      assert (HDR0 != HDR1) else $error("header bytes must differ");
      assert (DIG_BASE >= 2) else $error("digit window overlaps header");
      assert (DIG_BASE + NDIG < FRAME_LEN - 1) else $error("digit window must end before last byte");
      assert (STAT_IDX >= 2 && STAT_IDX < FRAME_LEN - 1) else $error("status byte out of range");
   end

   logic              body_we, last_byte;
   logic [CNT_W-1:0]  body_idx;
   logic [NDIG*8-1:0] raw_digits, codes;
   logic [1:0]        stat_bits, ovl_level;
   mfd_class_t        cls;

   mfd_hdr_sync #(.FRAME_LEN(FRAME_LEN), .HDR0(HDR0), .HDR1(HDR1)) u_sync (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .body_we(body_we), .body_idx(body_idx), .last_byte(last_byte));

   mfd_capture #(.FRAME_LEN(FRAME_LEN), .DIG_BASE(DIG_BASE), .STAT_IDX(STAT_IDX)) u_cap (
      .clk(clk), .rst_n(rst_n), .body_we(body_we), .body_idx(body_idx),
      .rx_byte(rx_byte), .raw_digits(raw_digits), .stat_bits(stat_bits));

   mfd_digit_lut u_lut (.raw_digits(raw_digits), .codes(codes));

   mfd_classify u_cls (.codes(codes), .stat_bits(stat_bits), .cls(cls), .ovl_level(ovl_level));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         digit_codes   <= '0;
         ovl_pattern   <= 1'b0;
         blank         <= 1'b0;
         partial_blank <= 1'b0;
         continuity    <= 1'b0;
         mode_change   <= 1'b0;
         frame_invalid <= 1'b0;
         ovl_flag      <= 2'd0;
         frame_done    <= 1'b0;
      end else begin
         frame_done <= last_byte;
         if (last_byte) begin
            digit_codes   <= codes;
            ovl_pattern   <= cls.ovl_pat;
            blank         <= cls.blank;
            partial_blank <= cls.part_blank;
            continuity    <= cls.cont;
            mode_change   <= cls.mode_chg;
            frame_invalid <= cls.invalid;
            ovl_flag      <= ovl_level;
         end
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done); // R10

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |-> ($stable(digit_codes) && $stable(ovl_flag) && $stable(frame_invalid))); // R10

   AST_NO_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !frame_invalid) |-> (digit_codes[7:0] != CODE_BAD && digit_codes[15:8] != CODE_BAD
                                          && digit_codes[23:16] != CODE_BAD && digit_codes[31:24] != CODE_BAD)); // R4

   AST_LEAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $onehot0({ovl_pattern, blank, partial_blank})); // R5

   AST_CONT_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !(continuity && mode_change)); // R7

   AST_FLAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (ovl_flag != 2'd3)); // R9

endmodule

// File: tb/sim_meter_frame_decoder.sv
module sim_meter_frame_decoder;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;

   typedef logic [7:0] frm_t [12];
   typedef struct packed {
      logic [31:0] dig;
      logic ovl, blk, part, cont, mode, inv;
      logic [1:0] flag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic [31:0] digit_codes;
   logic        ovl_pattern, blank, partial_blank, continuity, mode_change, frame_invalid;
   logic [1:0]  ovl_flag;
   logic        frame_done;

   int   n_vec = 0;
   int   n_bad = 0;
   int   n_done = 0;
   int   cyc = 0;
   exp_t sb_q [$];
   exp_t last_exp;
   logic prev_done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   meter_frame_decoder u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .digit_codes(digit_codes), .ovl_pattern(ovl_pattern), .blank(blank),
      .partial_blank(partial_blank), .continuity(continuity), .mode_change(mode_change),
      .frame_invalid(frame_invalid), .ovl_flag(ovl_flag), .frame_done(frame_done));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_lut(input logic [7:0] r);
      if (r <= 8'h09) return r;
      if (r == 8'h0A || r == 8'h0B || (r >= 8'h10 && r <= 8'h14)) return r;
      return 8'hFF;
   endfunction

   function automatic exp_t predict(input frm_t f);
      exp_t e;
      logic [7:0] c [4];
      for (int k = 0; k < 4; k++) begin
         c[k] = ref_lut({f[2+k][7:4], f[3+k][3:0]});
         e.dig[8*k +: 8] = c[k];
      end
      e.ovl  = (c[0] == 8'h0A && c[1] == 8'h0B);
      e.blk  = (c[0] == 8'h10 && c[1] == 8'h10);
      e.part = (c[0] == 8'h10 && c[1] == 8'h11);
      e.cont = (c[1] == 8'h12 && c[2] == 8'h0A && c[3] == 8'h05);
      e.mode = (c[1] == 8'h13 && c[2] == 8'h14);
      e.inv  = (c[0] == 8'hFF || c[1] == 8'hFF || c[2] == 8'hFF || c[3] == 8'hFF);
      e.flag = f[7][1] ? 2'd1 : (f[7][0] ? 2'd2 : 2'd0);
      return e;
   endfunction

   function automatic frm_t mk(input logic [7:0] d0, d1, d2, d3, st);
      frm_t f;
      f[0] = 8'h5A; f[1] = 8'hA5;
      f[2] = {d0[7:4], 4'h6};
      f[3] = {d1[7:4], d0[3:0]};
      f[4] = {d2[7:4], d1[3:0]};
      f[5] = {d3[7:4], d2[3:0]};
      f[6] = {4'h9, d3[3:0]};
      f[7] = st;
      f[8] = 8'h5A; f[9] = 8'hA5; f[10] = 8'hFF; f[11] = 8'h3C;
      return f;
   endfunction

   task automatic put(input logic [7:0] b, input int gap);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = b;
      if (gap > 0) begin
         @(negedge clk);
         rx_valid = 1'b0;
         rx_byte  = 8'h5A;
         repeat (gap - 1) @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      rx_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input frm_t f, input int gap);
      sb_q.push_back(predict(f));
      for (int i = 0; i < 12; i++) put(f[i], gap);
      idle(3);
   endtask

   task automatic check_held(input string req);
      chk(digit_codes == last_exp.dig, req, digit_codes, last_exp.dig);
      chk(ovl_flag == last_exp.flag && frame_invalid == last_exp.inv, req,
          {ovl_flag, frame_invalid}, {last_exp.flag, last_exp.inv});
   endtask

   // monitor: pops the scoreboard on every done strobe
   always @(negedge clk) begin
      if (rst_n) begin
         if (frame_done && prev_done) chk(1'b0, "R10 done width", 32'd2, 32'd1);
         if (frame_done) begin
            n_done++;
            if (sb_q.size() == 0) begin
               chk(1'b0, "R1 unexpected frame_done", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               last_exp = e;
               chk(digit_codes == e.dig, "R3/R4 digit codes", digit_codes, e.dig);
               chk(frame_invalid == e.inv, "R4 invalid", 32'(frame_invalid), 32'(e.inv));
               chk(ovl_pattern == e.ovl, "R5 overload pattern", 32'(ovl_pattern), 32'(e.ovl));
               chk(blank == e.blk && partial_blank == e.part, "R6 blank",
                   {blank, partial_blank}, {e.blk, e.part});
               chk(continuity == e.cont, "R7 continuity", 32'(continuity), 32'(e.cont));
               chk(mode_change == e.mode, "R8 mode change", 32'(mode_change), 32'(e.mode));
               chk(ovl_flag == e.flag, "R9 overload flag", 32'(ovl_flag), 32'(e.flag));
            end
         end
      end
      prev_done = frame_done;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == WATCHDOG) begin
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      last_exp = '0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(digit_codes == 32'h0 && ovl_flag == 2'd0 && frame_done == 1'b0, "R10 reset",
          {digit_codes[29:0], ovl_flag}, 32'h0);
      chk({ovl_pattern, blank, partial_blank, continuity, mode_change, frame_invalid} == 6'b0,
          "R10 reset flags", 32'({ovl_pattern, blank, partial_blank, continuity, mode_change, frame_invalid}), 32'h0);
      rst_n = 1'b1;
      idle(2);

      send(mk(8'h01, 8'h02, 8'h03, 8'h04, 8'h02), 0);   // R3 plain digits, R9 flag 1
      // R1 stray bytes and R2 broken header: no frame, outputs hold
      put(8'hA5, 0); put(8'h00, 0); put(8'h5A, 0); put(8'h33, 0); put(8'hA5, 0); put(8'h12, 0);
      idle(4);
      check_held("R1 stray bytes ignored");
      // R2 repeated first header byte before the real second one
      begin
         frm_t f;
         f = mk(8'h0A, 8'h0B, 8'h07, 8'h08, 8'h01);    // R5 OL, R9 flag 2
         sb_q.push_back(predict(f));
         put(8'h5A, 0); put(8'h00, 0);
         for (int i = 0; i < 12; i++) put(f[i], 0);
         idle(3);
      end
      begin
         frm_t f;
         f = mk(8'h10, 8'h10, 8'h05, 8'h06, 8'h03);    // R6 blank, R9 priority
         sb_q.push_back(predict(f));
         put(8'h5A, 0); put(8'h5A, 0);
         for (int i = 1; i < 12; i++) put(f[i], 0);
         idle(3);
      end
      send(mk(8'h10, 8'h11, 8'h00, 8'h09, 8'h00), 0);   // R6 partial blank
      send(mk(8'h04, 8'h12, 8'h0A, 8'h05, 8'h00), 2);   // R7 with R11 gaps
      send(mk(8'h09, 8'h13, 8'h14, 8'h00, 8'hFC), 1);   // R8, R9 none
      send(mk(8'h01, 8'h02, 8'h3C, 8'h04, 8'h00), 0);   // R4 undefined raw value
      send(mk(8'h0C, 8'h15, 8'h0F, 8'hFF, 8'h00), 0);   // R4 near-miss specials
      send(mk(8'h0A, 8'h0A, 8'h10, 8'h12, 8'h00), 3);   // R5 negative case
      idle(5);
      check_held("R10 hold after frame");
      chk(sb_q.size() == 0, "R10 frames completed", 32'(sb_q.size()), 32'd0);
      chk(n_done == 9, "R10 done count", 32'(n_done), 32'd9);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule